// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns a fast reference tick into a sample-rate strobe whose average rate is an exact rational fraction of the reference. It holds several independent generator channels, three by default. Each channel selects one of three reference tick streams: the 48 kHz family, the 44.1 kHz family, or the tick recovered from a digital audio receiver. The reference clocks themselves are produced elsewhere and arrive here as single-cycle enable pulses on the system clock.

Each channel keeps an error accumulator. On every tick of its chosen reference it adds a programmed increment. Whenever the running value reaches the modulus, the modulus is taken off and the channel emits a one-cycle strobe. The strobe rate is therefore increment/modulus times the reference rate. The modulus is not written directly: software writes a control value equal to the modulus minus one, masked to 16 bits.

Each channel has two configuration words, written through a small write port: a source-select word and a rate word. Writing either word restarts that channel's accumulator from zero.

Top module: `frac_rate_gen`

## Requirements
- R1: After reset, every channel has source 0, increment 0, modulus control 0 and an empty accumulator, and `rate_strobe` is all zero.
- R2: Source-select value 0 follows `ref_tick[0]`, value 1 follows `ref_tick[1]` and value 2 follows `ref_tick[2]`. Ticks on references that a channel has not selected have no effect on that channel.
- R3: Source-select value 3 is reserved and stops the channel. While the channel is stopped, no tick advances its accumulator and it produces no strobe.
- R4: Word 0 (`cfg_word`=0) takes the source select from `cfg_wdata[1:0]`. Word 1 (`cfg_word`=1) takes the increment from `cfg_wdata[15:0]` and the modulus control from `cfg_wdata[31:16]`. The modulus is the control value plus one, in the range 1 to 65536.
- R5: On a selected tick, the channel forms sum = accumulator + increment. If sum is at least the modulus, the accumulator becomes sum minus the modulus and a strobe is produced. Otherwise the accumulator becomes sum and no strobe is produced.
- R6: Starting from a cleared accumulator with increment no larger than the modulus, the k-th selected tick produces a strobe exactly when floor(k·inc/mod) differs from floor((k-1)·inc/mod).
- R7: When the increment equals the modulus, every selected tick produces a strobe. When the increment is 0, no strobe is ever produced.
- R8: A write to either word of a channel clears its accumulator to zero. A tick that arrives in the same cycle as that write is ignored.
- R9: Channels are independent. A write addresses only the channel named by `cfg_unit`, and a write to a channel number of N_GEN or above changes nothing.
- R10: The strobe is a registered output. A tick sampled at clock edge n shows as a strobe during the cycle after edge n, high for exactly one cycle, and the strobe is low after any cycle with no selected tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | N_SRC (3) | Reference enable pulses: [0] 48 kHz family, [1] 44.1 kHz family, [2] recovered receiver tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | UNIT_W (2) | Channel number to write |
| cfg_word | input | 1 | 0 = source-select word, 1 = rate word |
| cfg_wdata | input | 2*INC_W (32) | Write data |
| rate_strobe | output | N_GEN (3) | One-cycle sample strobe per channel |

## Verification
The bench builds the block with its default parameters: three channels, three references and a 16-bit increment. With these values the unused channel number 3 exists on the 2-bit `cfg_unit` port, so writes that must be ignored can be driven. The full-width modulus of 65536 is also exercised, together with an increment of 0x8000, which pushes the accumulator sum into its 17th bit. Several increment/modulus ratios are checked tick by tick against the floor formula. Additional cases cover the reserved source, a write that coincides with a tick, and a rate rewrite in the middle of a sequence.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_48K   = 2'd0,
    SRC_44K   = 2'd1,
    SRC_RECOV = 2'd2,
    SRC_STOP  = 2'd3
  } src_sel_e;

  localparam logic CFG_WORD_SRC  = 1'b0;
  localparam logic CFG_WORD_RATE = 1'b1;
endpackage

// File: rtl/frac_rate_srcsel.sv
module frac_rate_srcsel
  import frac_rate_pkg::*;
#(
  parameter int N_SRC = 3
) (
  input  src_sel_e         sel,
  input  logic [N_SRC-1:0] ref_tick,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_hit
    assign hit[i] = (sel == src_sel_e'(i)) && ref_tick[i];
  end

  assign tick = |hit;
endmodule

// File: rtl/frac_rate_accum.sv
module frac_rate_accum
  import frac_rate_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_word,
  input  logic [2*INC_W-1:0] wr_data,
  input  logic               tick,
  output src_sel_e           src_sel,
  output logic               strobe
);
  localparam int ACC_W = INC_W + 1;
  localparam int SUM_W = INC_W + 2;

  src_sel_e           src_q;
  logic [INC_W-1:0]   inc_q;
  logic [INC_W-1:0]   mctl_q;
  logic [ACC_W-1:0]   acc_q;
  logic               strobe_q;
  logic [SUM_W-1:0]   sum;
  logic [SUM_W-1:0]   modulus;
  logic               wrap;

  assign sum     = SUM_W'(acc_q) + SUM_W'(inc_q);
  assign modulus = SUM_W'(mctl_q) + SUM_W'(1);
  assign wrap    = (sum >= modulus);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= SRC_48K;
      inc_q    <= '0;
      mctl_q   <= '0;
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (wr_en) begin
        if (wr_word == CFG_WORD_RATE) begin
          inc_q  <= wr_data[INC_W-1:0];
          mctl_q <= wr_data[2*INC_W-1:INC_W];
        end else begin
          src_q <= src_sel_e'(wr_data[SEL_W-1:0]);
        end
        acc_q <= '0;
      end else if (tick) begin
        if (wrap) begin
          acc_q    <= ACC_W'(sum - modulus);
          strobe_q <= 1'b1;
        end else begin
          acc_q <= ACC_W'(sum);
        end
      end
    end
  end

  assign src_sel = src_q;
  assign strobe  = strobe_q;

  // R5: accumulator stays below the modulus while increment <= modulus
  a_r5_acc_bound: assert property (@(posedge clk) disable iff (rst)
    (SUM_W'(inc_q) <= modulus) |-> (SUM_W'(acc_q) < modulus));

  // R8: a configuration write leaves an empty accumulator
  a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (acc_q == '0) && !strobe_q);

  // R3: reserved source freezes the channel
  a_r3_stop_frozen: assert property (@(posedge clk) disable iff (rst)
    (src_q == SRC_STOP && !wr_en) |=> $stable(acc_q) && !strobe_q);

  // R7: zero increment never strobes
  a_r7_zero_inc: assert property (@(posedge clk) disable iff (rst)
    (inc_q == '0 && !wr_en) |=> !strobe_q);

  // R10: no strobe without a selected tick in the previous cycle
  a_r10_strobe_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !strobe_q);
endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen
  import frac_rate_pkg::*;
#(
  parameter int N_GEN = 3,
  parameter int N_SRC = 3,
  parameter int INC_W = 16,
  localparam int UNIT_W = (N_GEN > 1) ? $clog2(N_GEN) : 1,
  localparam int DATA_W = 2 * INC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  ref_tick,
  input  logic              cfg_we,
  input  logic [UNIT_W-1:0] cfg_unit,
  input  logic              cfg_word,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [N_GEN-1:0]  rate_strobe
);
  for (genvar g = 0; g < N_GEN; g++) begin : g_chan
    src_sel_e sel;
    logic     tick;
    logic     wr_en;

    assign wr_en = cfg_we && (cfg_unit == UNIT_W'(g));

    frac_rate_srcsel #(.N_SRC(N_SRC)) u_sel (
      .sel      (sel),
      .ref_tick (ref_tick),
      .tick     (tick)
    );

    frac_rate_accum #(.INC_W(INC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_word (cfg_word),
      .wr_data (cfg_wdata),
      .tick    (tick),
      .src_sel (sel),
      .strobe  (rate_strobe[g])
    );
  end

  // R1: strobes are quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (rate_strobe == '0));
endmodule

// File: tb/frac_rate_gen_bench.sv
module frac_rate_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ref_tick = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_unit = '0;
  logic        cfg_word = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  rate_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frac_rate_gen u_frac_rate_gen (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_we(cfg_we),
    .cfg_unit(cfg_unit), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .rate_strobe(rate_strobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] unit, input logic word, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_unit = unit; cfg_word = word; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input logic [2:0] m, output logic [2:0] s);
    @(negedge clk);
    ref_tick = m;
    @(negedge clk);
    ref_tick = '0;
    s = rate_strobe;
  endtask

  function automatic bit exp_bit(input longint k, input longint inc, input longint md);
    return ((k * inc) / md) != (((k - 1) * inc) / md);
  endfunction

  task automatic rate_seq(input logic [1:0] unit, input int src, input int inc,
                          input int mctl, input int n, input string req);
    logic [2:0] s;
    wr(unit, 1'b0, 32'(src));
    wr(unit, 1'b1, {16'(mctl), 16'(inc)});
    for (int k = 1; k <= n; k++) begin
      tick(3'b1 << src, s);
      check(s[unit] == exp_bit(k, inc, longint'(mctl) + 1), req, s[unit],
            exp_bit(k, inc, longint'(mctl) + 1));
    end
  endtask

  task automatic t_reset;
    logic [2:0] s;
    check(rate_strobe == 3'b000, "R1 reset strobes", rate_strobe, 0);
    for (int k = 0; k < 4; k++) begin
      tick(3'b111, s);
      check(s == 3'b000, "R1 R7 zero increment after reset", s, 0);
    end
  endtask

  task automatic t_ratio;
    rate_seq(2'd0, 0, 3, 7, 16, "R5 R6 R4 ratio 3/8");
    rate_seq(2'd1, 1, 5, 12, 26, "R6 ratio 5/13");
    rate_seq(2'd2, 2, 16'h8000, 16'hFFFF, 6, "R4 R6 full modulus 65536");
  endtask

  task automatic t_equal;
    logic [2:0] s;
    wr(2'd1, 1'b0, 32'd1);
    wr(2'd1, 1'b1, {16'd4, 16'd5});
    for (int k = 0; k < 4; k++) begin
      tick(3'b010, s);
      check(s[1] == 1'b1, "R7 inc equals modulus", s[1], 1);
      @(negedge clk);
      check(rate_strobe[1] == 1'b0, "R10 one-cycle strobe", rate_strobe[1], 0);
    end
    tick(3'b101, s);
    check(s[1] == 1'b0, "R2 unselected refs ignored", s[1], 0);
    wr(2'd1, 1'b1, {16'd0, 16'd1});
    tick(3'b010, s);
    check(s[1] == 1'b1, "R7 modulus 1 every tick", s[1], 1);
  endtask

  task automatic t_select;
    logic [2:0] s;
    wr(2'd2, 1'b0, 32'd2);
    wr(2'd2, 1'b1, {16'd1, 16'd1});
    for (int k = 0; k < 3; k++) begin
      tick(3'b011, s);
      check(s[2] == 1'b0, "R2 refs 0/1 ignored by source 2", s[2], 0);
    end
    tick(3'b100, s);
    check(s[2] == 1'b0, "R2 first recovered tick", s[2], 0);
    tick(3'b100, s);
    check(s[2] == 1'b1, "R2 second recovered tick", s[2], 1);
  endtask

  task automatic t_reserved;
    logic [2:0] s;
    wr(2'd0, 1'b1, {16'd3, 16'd4});
    wr(2'd0, 1'b0, 32'd3);
    for (int k = 0; k < 4; k++) begin
      tick(3'b111, s);
      check(s[0] == 1'b0, "R3 reserved source stops", s[0], 0);
    end
    wr(2'd0, 1'b0, 32'd0);
    tick(3'b001, s);
    check(s[0] == 1'b1, "R3 resumes after leaving reserved", s[0], 1);
  endtask

  task automatic t_clear;
    logic [2:0] s;
    wr(2'd0, 1'b0, 32'd0);
    wr(2'd0, 1'b1, {16'd7, 16'd3});
    tick(3'b001, s);
    tick(3'b001, s);
    wr(2'd0, 1'b1, {16'd7, 16'd3});
    tick(3'b001, s);
    check(s[0] == 1'b0, "R8 rewrite clears accumulator", s[0], 0);
    tick(3'b001, s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_unit = 2'd0; cfg_word = 1'b0; cfg_wdata = 32'd0;
    ref_tick = 3'b001;
    @(negedge clk);
    cfg_we = 1'b0; ref_tick = '0;
    check(rate_strobe[0] == 1'b0, "R8 tick during write ignored", rate_strobe[0], 0);
    for (int k = 1; k <= 8; k++) begin
      tick(3'b001, s);
      check(s[0] == exp_bit(k, 3, 8), "R8 fresh sequence after write", s[0], exp_bit(k, 3, 8));
    end
  endtask

  task automatic t_unit_ignore;
    logic [2:0] s;
    wr(2'd0, 1'b1, {16'd7, 16'd3});
    tick(3'b001, s);
    tick(3'b001, s);
    wr(2'd3, 1'b1, {16'd0, 16'd0});
    wr(2'd3, 1'b0, 32'd3);
    tick(3'b001, s);
    check(s[0] == 1'b1, "R9 unit 3 write ignored", s[0], 1);
    wr(2'd1, 1'b1, {16'd0, 16'd0});
    tick(3'b001, s);
    tick(3'b001, s);
    tick(3'b001, s);
    check(s[0] == 1'b1, "R9 other channel write leaves unit 0", s[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ratio();
    t_equal();
    t_select();
    t_reserved();
    t_clear();
    t_unit_ignore();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule